// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block tracks the power state of a processor core through four states: Run (the combined normal and stop-grant state), Sleep, Deep Sleep and a Relock state. Relock is a timed wait for the clock generator to stabilise after Deep Sleep ends. Software and the platform request the low-power states through two active-low request lines. A stop-grant level input qualifies entry into Sleep. An active-low reset returns the block to Run from any state, with no intermediate step.

The block runs from a free-running timing clock that keeps toggling while the bus clock is gated. It drives four outputs:
- the current state;
- an enable for the bus-clock gate;
- an enable that tells the bus interface whether snoops and interrupts may be accepted;
- a sticky violation flag.

The violation flag is raised by bus activity while the core is in a low-power state, and by a deep-sleep request made outside Sleep. The length of the Relock wait is a cycle-count parameter. Its default, 1875 cycles, is 15 µs at 125 MHz.

Top module: `pwr_state_seq`

## Requirements
- R1: From Run, the state moves to Sleep only when the sleep request is asserted (low) and the stop-grant input is high. A sleep request without stop-grant leaves the state at Run.
- R2: The state moves to Deep Sleep only from Sleep, when the deep-sleep request is asserted (low). In Sleep, a deep-sleep request takes priority over a deasserted sleep request.
- R3: In Deep Sleep, deasserting the deep-sleep request moves the state to Relock. The state stays in Relock for exactly RELOCK_CYCLES cycles and then moves to Sleep.
- R4: In Sleep, deasserting the sleep request while no deep-sleep request is present returns the state to Run.
- R5: Asserting reset sets the state to Run at once from any state, including Sleep. While reset is held, the bus-clock enable and the accept enable are 1 and the violation flag is 0.
- R6: The accept enable is 1 exactly when the state output is Run.
- R7: With the default gate delay of 0, the bus-clock enable falls one cycle after the state shows Deep Sleep. It rises one cycle after the state leaves Deep Sleep, which is within 10 cycles of the deep-sleep request deasserting. It is 1 in every other state.
- R8: A snoop or interrupt input that is high while the state is Sleep, Deep Sleep or Relock sets the violation flag. The same input while the state is Run does not set it.
- R9: A deep-sleep request seen while the state is Run or Relock leaves the state unchanged and sets the violation flag.
- R10: Once set, the violation flag stays at 1 until reset.
- R11: The state output is encoded as Run = 2'b00, Sleep = 2'b01, Deep Sleep = 2'b11 and Relock = 2'b10.
- R12: Every request, stop-grant, snoop and interrupt input passes through a two-stage synchroniser. A change driven between clock edges therefore changes the state and the violation flag at the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_req_n | input | 1 | Sleep request, active low |
| dslp_req_n | input | 1 | Deep-sleep request, active low |
| stop_grant_i | input | 1 | Stop-grant level, high when the core has granted a stop |
| snoop_i | input | 1 | Snoop request from the bus |
| intr_i | input | 1 | Interrupt request |
| state_o | output | 2 | Current power state (encoding in R11) |
| bus_clk_en_o | output | 1 | Bus-clock gate enable, 0 stops the bus clock |
| accept_en_o | output | 1 | Snoop and interrupt accept enable |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench drives inputs on falling edges. It counts three rising edges (two synchroniser stages plus the state register) before the state, accept-enable and violation results are due. The bus-clock enable is due one edge later still. Every stimulus task pushes each expected value into the scoreboard tagged with the exact cycle it is due. The monitor compares an item only on the falling edge of that cycle. The bench also checks one cycle early where a result must not yet have moved, and it checks the Relock length at both its last cycle and the first Sleep cycle, so an off-by-one in either direction is reported.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // State encoding is visible at the port (R11)
    typedef enum logic [1:0] {
        PS_RUN    = 2'b00,
        PS_SLEEP  = 2'b01,
        PS_RELOCK = 2'b10,
        PS_DEEP   = 2'b11
    } pstate_e;

    // Bit positions inside the synchronised input bundle
    localparam int IN_SLP_N  = 0;
    localparam int IN_DSLP_N = 1;
    localparam int IN_SG     = 2;
    localparam int IN_SNOOP  = 3;
    localparam int IN_INTR   = 4;
    localparam int IN_W      = 5;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int RELOCK_CYCLES = 1875
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp_req_i,
    input  logic       dslp_req_i,
    input  logic       sg_i,
    input  logic       snoop_i,
    input  logic       intr_i,
    output pstate_e    state_o,
    output logic       in_deep_o,
    output logic       accept_o,
    output logic       viol_o
);

    localparam int CW = (RELOCK_CYCLES > 2) ? $clog2(RELOCK_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RELOCK_CYCLES - 1);

    typedef struct packed {
        pstate_e         state;
        logic [CW-1:0]   cnt;
        logic            accept;
        logic            viol;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic bad_dslp, bad_bus;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            PS_RUN: begin
                if (slp_req_i && sg_i) r_d.state = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (dslp_req_i)      r_d.state = PS_DEEP;
                else if (!slp_req_i) r_d.state = PS_RUN;
            end
            PS_DEEP: begin
                if (!dslp_req_i) begin
                    r_d.state = PS_RELOCK;
                    r_d.cnt   = LOAD;
                end
            end
            PS_RELOCK: begin
                if (r_q.cnt == '0) r_d.state = PS_SLEEP;
                else               r_d.cnt   = r_q.cnt - 1'b1;
            end
            default: r_d.state = PS_RUN;
        endcase

        bad_dslp  = dslp_req_i && (r_q.state == PS_RUN || r_q.state == PS_RELOCK);
        bad_bus   = (snoop_i || intr_i) && (r_q.state != PS_RUN);
        r_d.viol  = r_q.viol | bad_dslp | bad_bus;
        r_d.accept = (r_d.state == PS_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= PS_RUN;
            r_q.cnt    <= '0;
            r_q.accept <= 1'b1;
            r_q.viol   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.state;
    assign in_deep_o = (r_q.state == PS_DEEP);
    assign accept_o  = r_q.accept;
    assign viol_o    = r_q.viol;

    // R1: Run may only stay or go to Sleep
    assert_run_exits_sleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_RUN) |=> (r_q.state == PS_RUN || r_q.state == PS_SLEEP));

    // R2: Deep Sleep is reached only from Sleep
    assert_deep_from_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != PS_SLEEP && r_q.state != PS_DEEP) |=> (r_q.state != PS_DEEP));

    // R3: Deep Sleep leaves only through Relock, Relock only into Sleep
    assert_deep_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_DEEP) |=> (r_q.state == PS_DEEP || r_q.state == PS_RELOCK));
    assert_relock_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_RELOCK) |=> (r_q.state == PS_RELOCK || r_q.state == PS_SLEEP));
    assert_relock_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_RELOCK) |-> (r_q.cnt <= LOAD));

    // R8: bus activity in a low-power state is flagged next cycle
    assert_bus_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((snoop_i || intr_i) && r_q.state != PS_RUN) |=> r_q.viol);

    // R10: violation flag is sticky
    assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.viol |=> r_q.viol);

endmodule

// File: rtl/pwr_seq_clkgate.sv
module pwr_seq_clkgate #(
    parameter bit STOP_CLK = 1'b1,
    parameter int OFF_DLY  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_deep_i,
    output logic en_o
);

    localparam int DW = $clog2(OFF_DLY + 2);
    localparam logic [DW-1:0] LIM = DW'(OFF_DLY);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          en;
    } gate_regs_t;

    gate_regs_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!in_deep_i) begin
            g_d.cnt = '0;
            g_d.en  = 1'b1;
        end else if (g_q.cnt == LIM) begin
            g_d.en  = !STOP_CLK;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.cnt <= '0;
            g_q.en  <= 1'b1;
        end else begin
            g_q <= g_d;
        end
    end

    assign en_o = g_q.en;

    // R7: the bus clock is only stopped after a cycle spent in Deep Sleep
    assert_gate_in_deep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !g_q.en |-> $past(in_deep_i));

    // R7: leaving Deep Sleep restarts the clock on the next edge
    assert_gate_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_deep_i |=> g_q.en);

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int RELOCK_CYCLES = 1875,
    parameter int SYNC_STAGES   = 2,
    parameter bit STOP_CLK      = 1'b1,
    parameter int GATE_DLY      = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp_req_n,
    input  logic       dslp_req_n,
    input  logic       stop_grant_i,
    input  logic       snoop_i,
    input  logic       intr_i,
    output logic [1:0] state_o,
    output logic       bus_clk_en_o,
    output logic       accept_en_o,
    output logic       viol_o
);

    localparam logic [IN_W-1:0] IDLE_IN = (IN_W'(1) << IN_SLP_N) | (IN_W'(1) << IN_DSLP_N);

    logic [IN_W-1:0] raw_in, syn_in;
    pstate_e         cur_state;
    logic            in_deep;

    always_comb begin
        raw_in            = '0;
        raw_in[IN_SLP_N]  = slp_req_n;
        raw_in[IN_DSLP_N] = dslp_req_n;
        raw_in[IN_SG]     = stop_grant_i;
        raw_in[IN_SNOOP]  = snoop_i;
        raw_in[IN_INTR]   = intr_i;
    end

    pwr_seq_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_IN)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    pwr_seq_fsm #(
        .RELOCK_CYCLES (RELOCK_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slp_req_i  (!syn_in[IN_SLP_N]),
        .dslp_req_i (!syn_in[IN_DSLP_N]),
        .sg_i       (syn_in[IN_SG]),
        .snoop_i    (syn_in[IN_SNOOP]),
        .intr_i     (syn_in[IN_INTR]),
        .state_o    (cur_state),
        .in_deep_o  (in_deep),
        .accept_o   (accept_en_o),
        .viol_o     (viol_o)
    );

    pwr_seq_clkgate #(
        .STOP_CLK (STOP_CLK),
        .OFF_DLY  (GATE_DLY)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_deep_i (in_deep),
        .en_o      (bus_clk_en_o)
    );

    assign state_o = cur_state;

    // R6: accept enable and Run state agree at the port
    assert_accept_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_en_o == (state_o == 2'b00));

endmodule

// File: tb/pwr_state_seq_test.sv
`timescale 1ns/1ps
module pwr_state_seq_test;

    localparam int N = 1875;
    localparam int SIG_ST = 0, SIG_CK = 1, SIG_AC = 2, SIG_VI = 3;

    logic       clk = 1'b0;
    logic       rst_n, slp_req_n, dslp_req_n, stop_grant_i, snoop_i, intr_i;
    logic [1:0] state_o;
    logic       bus_clk_en_o, accept_en_o, viol_o;

    int cyc = 0, compared = 0, mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    sig;
        int    val;
        string req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_state_seq uut (
        .clk(clk), .rst_n(rst_n), .slp_req_n(slp_req_n), .dslp_req_n(dslp_req_n),
        .stop_grant_i(stop_grant_i), .snoop_i(snoop_i), .intr_i(intr_i),
        .state_o(state_o), .bus_clk_en_o(bus_clk_en_o),
        .accept_en_o(accept_en_o), .viol_o(viol_o)
    );

    function automatic int sample(int sig);
        case (sig)
            SIG_ST:  return int'(state_o);
            SIG_CK:  return int'(bus_clk_en_o);
            SIG_AC:  return int'(accept_en_o);
            default: return int'(viol_o);
        endcase
    endfunction

    task automatic expect_at(int dly, int sig, int val, string req);
        item_t it;
        it.due = cyc + dly;
        it.sig = sig;
        it.val = val;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                int act;
                act = sample(sb[i].sig);
                compared++;
                if (act != sb[i].val) begin
                    mismatched++;
                    $display("FAIL %s cycle %0d sig %0d: actual %0d expected %0d",
                             sb[i].req, cyc, sb[i].sig, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        rst_n = 1'b0; slp_req_n = 1'b1; dslp_req_n = 1'b1;
        stop_grant_i = 1'b0; snoop_i = 1'b0; intr_i = 1'b0;
        tick(3);
        rst_n = 1'b1;
        expect_at(1, SIG_ST, 0, "R5");
        expect_at(1, SIG_CK, 1, "R5");
        expect_at(1, SIG_AC, 1, "R6");
        expect_at(1, SIG_VI, 0, "R5");
        tick(4);

        // R1: sleep request without stop-grant is held off
        slp_req_n = 1'b0;
        expect_at(4, SIG_ST, 0, "R1");
        tick(6);
        stop_grant_i = 1'b1;
        expect_at(2, SIG_ST, 0, "R12");
        expect_at(3, SIG_ST, 1, "R1");   // R11 Sleep = 01
        expect_at(3, SIG_AC, 0, "R6");
        tick(6);

        // R2: Sleep to Deep Sleep, clock gate R7
        dslp_req_n = 1'b0;
        expect_at(2, SIG_ST, 1, "R12");
        expect_at(3, SIG_ST, 3, "R2");   // R11 Deep = 11
        expect_at(3, SIG_CK, 1, "R7");
        expect_at(4, SIG_CK, 0, "R7");
        expect_at(4, SIG_AC, 0, "R6");
        tick(8);

        // R3: Relock then Sleep; R7 restart
        dslp_req_n = 1'b1;
        expect_at(3, SIG_ST, 2, "R3");   // R11 Relock = 10
        expect_at(3, SIG_CK, 0, "R7");
        expect_at(4, SIG_CK, 1, "R7");
        expect_at(3 + N - 1, SIG_ST, 2, "R3");
        expect_at(3 + N, SIG_ST, 1, "R3");
        tick(N + 6);

        // R4: Sleep back to Run
        slp_req_n = 1'b1;
        expect_at(3, SIG_ST, 0, "R4");
        expect_at(3, SIG_AC, 1, "R6");
        expect_at(3, SIG_VI, 0, "R8");
        tick(6);

        // R8: snoop in Run is legal
        snoop_i = 1'b1;
        expect_at(4, SIG_VI, 0, "R8");
        tick(6);
        snoop_i = 1'b0;
        tick(4);

        // R9: deep request in Run ignored and flagged
        dslp_req_n = 1'b0;
        expect_at(2, SIG_VI, 0, "R12");
        expect_at(3, SIG_ST, 0, "R9");
        expect_at(3, SIG_VI, 1, "R9");
        tick(6);
        dslp_req_n = 1'b1;
        tick(4);
        expect_at(1, SIG_ST, 0, "R9");
        expect_at(1, SIG_VI, 1, "R10");
        tick(2);
        rst_n = 1'b0;
        expect_at(1, SIG_VI, 0, "R5");
        tick(2);
        rst_n = 1'b1;
        tick(4);

        // R8: interrupt in Sleep flagged, R10 sticky
        slp_req_n = 1'b0;
        tick(6);
        expect_at(1, SIG_ST, 1, "R1");
        tick(2);
        intr_i = 1'b1;
        expect_at(2, SIG_VI, 0, "R8");
        expect_at(3, SIG_VI, 1, "R8");
        tick(4);
        intr_i = 1'b0;
        tick(6);
        expect_at(1, SIG_VI, 1, "R10");
        expect_at(1, SIG_ST, 1, "R10");
        tick(2);

        // R5: reset in Sleep goes straight to Run
        rst_n = 1'b0;
        slp_req_n = 1'b1;
        expect_at(1, SIG_ST, 0, "R5");
        expect_at(1, SIG_AC, 1, "R5");
        expect_at(1, SIG_VI, 0, "R5");
        expect_at(1, SIG_CK, 1, "R5");
        tick(3);
        rst_n = 1'b1;
        expect_at(5, SIG_ST, 0, "R5");
        tick(8);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule